// File: doc/BRIEF.md
# Serial-Clocked Bi-phase / Manchester Modulator

This block drives the coil damping control line from a raw bit stream carried on the two-wire serial bus. When the bus decoder has received and acknowledged a control byte that asks for modulation, the block arms. From then on every SCL high phase carries one data bit on SDA. The block turns the stream into a Bi-phase or Manchester coded level on `mod_o`, where 1 damps the coil and 0 leaves it undamped. Bits flow with no byte framing and no acknowledge slots.

Each bit period starts at a rising SCL edge. The falling SCL edge marks mid-bit. The mode ends at the next STOP condition. While the block is armed it raises `bus_hold_o` so that the neighbouring memory controller keeps off the bus. SCL and SDA arrive already synchronized to `clk`, and the START/STOP detection is done outside this block.

Top module: `sermod_top`

## Requirements
- R1: After a synchronous reset, `mod_o` is 0 and `bus_hold_o` is 0.
- R2: A strobe on `ctrl_valid_i` arms the block when `ctrl_byte_i` bits 7..5 equal 110 and bits 2..0 equal 111. Bit 4 picks the coding: 0 selects Bi-phase and 1 selects Manchester. Bit 3 is ignored.
- R3: Any other control byte leaves the block unarmed. This includes bytes with bits 7..5 = 111 (supply control) and every byte whose bits 2..0 are 110. With such a byte, `mod_o` stays 0 and `bus_hold_o` stays 0 however SCL and SDA move.
- R4: `bus_hold_o` rises one clock after an arming strobe and falls one clock after STOP.
- R5: In Manchester coding, a rising SCL edge sets `mod_o` to the SDA bit and the following falling edge sets it to the inverse of that bit. So a 1 is sent high then low, and a 0 low then high.
- R6: In Bi-phase coding, `mod_o` toggles on every rising SCL edge and toggles again on the falling edge when the bit is 0.
- R7: `mod_o` is 0 whenever the block is not armed, and it starts at 0 when the block arms.
- R8: STOP disarms the block and forces `mod_o` to 0 on the next clock. STOP takes priority over an SCL edge or a strobe in the same cycle.
- R9: Control strobes that arrive while the block is armed are ignored, so the coding chosen at arming is kept until STOP.
- R10: `mod_o` changes on the first clock edge that samples a new SCL level and at no other time. SDA changes while SCL is low have no effect.
- R11: Bits stream without limit: runs longer than 8 bits are coded the same way, with no acknowledge gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock, used as the bit clock |
| sda_i | input | 1 | Synchronized serial data, used as the bit value |
| ctrl_valid_i | input | 1 | One-cycle strobe: an acknowledged control byte is ready |
| ctrl_byte_i | input | 8 | The control byte that goes with the strobe |
| stop_i | input | 1 | One-cycle STOP condition indication |
| mod_o | output | 1 | Damping control, 1 = damped |
| bus_hold_o | output | 1 | High while the modulator owns the bus |

## Verification
Every result of this block is registered once. A strobe, an SCL level change or a STOP that is sampled on a rising `clk` edge shows up on `mod_o` or `bus_hold_o` right after that edge. The bench drives its inputs on the falling edge and samples the outputs on the next falling edge, so each expected value is due exactly one half-period after the edge that caused it. A behavioural model in the bench applies the same one-edge rule and is compared with both outputs on every clock. Hand-computed waveforms for each coding, each non-arming byte class and each STOP collision are then checked at the matching falling edges.

// File: rtl/sermod_pkg.sv
package sermod_pkg;
  typedef enum logic {
    CODE_BIPHASE = 1'b0,
    CODE_MANCH   = 1'b1
  } code_e;
endpackage

// File: rtl/sermod_edge.sv
module sermod_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  // idle bus level is high, so no edge is seen right after reset
  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b1;
    else     scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/sermod_ctrl.sv
module sermod_ctrl
  import sermod_pkg::*;
#(
  parameter int          CTRL_W   = 8,
  parameter logic [7:0]  ARM_VAL  = 8'b1100_0111,
  parameter logic [7:0]  ARM_MASK = 8'b1110_0111,
  parameter int          SEL_POS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_valid_i,
  input  logic [CTRL_W-1:0] ctrl_byte_i,
  input  logic              stop_i,
  output logic              armed_o,
  output code_e             code_o
);
  localparam logic [CTRL_W-1:0] MASK_W = CTRL_W'(ARM_MASK);
  localparam logic [CTRL_W-1:0] VAL_W  = CTRL_W'(ARM_VAL);

  logic hit;
  assign hit = ((ctrl_byte_i & MASK_W) == VAL_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o <= 1'b0;
      code_o  <= CODE_BIPHASE;
    end else if (stop_i) begin
      armed_o <= 1'b0;
    end else if (!armed_o && ctrl_valid_i && hit) begin
      armed_o <= 1'b1;
      code_o  <= code_e'(ctrl_byte_i[SEL_POS]);
    end
  end

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !armed_o);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_o && !stop_i) |=> (armed_o && $stable(code_o)));
endmodule

// File: rtl/sermod_enc.sv
module sermod_enc
  import sermod_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  armed_i,
  input  code_e code_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  sda_i,
  input  logic  stop_i,
  output logic  mod_o
);
  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_o <= 1'b0;
      bit_q <= 1'b0;
    end else if (stop_i || !armed_i) begin
      mod_o <= 1'b0;
    end else if (rise_i) begin
      bit_q <= sda_i;
      mod_o <= (code_i == CODE_MANCH) ? sda_i : ~mod_o;
    end else if (fall_i) begin
      if (code_i == CODE_MANCH) mod_o <= ~bit_q;
      else if (!bit_q)          mod_o <= ~mod_o;
    end
  end

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_i |-> !mod_o);

  // R5
  manch_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_i && code_i == CODE_MANCH && rise_i && !stop_i) |=> (mod_o == $past(sda_i)));

  // R6
  biph_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_i && code_i == CODE_BIPHASE && rise_i && !stop_i) |=> (mod_o != $past(mod_o)));

  // R10
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise_i && !fall_i && !stop_i) |=> $stable(mod_o));
endmodule

// File: rtl/sermod_top.sv
module sermod_top
  import sermod_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ctrl_valid_i,
  input  logic [CTRL_W-1:0] ctrl_byte_i,
  input  logic              stop_i,
  output logic              mod_o,
  output logic              bus_hold_o
);
  logic  rise, fall, armed;
  code_e code;

  sermod_edge u_edge (
    .clk(clk), .rst(rst), .scl_i(scl_i), .rise_o(rise), .fall_o(fall)
  );

  sermod_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctrl_valid_i(ctrl_valid_i), .ctrl_byte_i(ctrl_byte_i),
    .stop_i(stop_i), .armed_o(armed), .code_o(code)
  );

  sermod_enc u_enc (
    .clk(clk), .rst(rst), .armed_i(armed), .code_i(code), .rise_i(rise),
    .fall_i(fall), .sda_i(sda_i), .stop_i(stop_i), .mod_o(mod_o)
  );

  assign bus_hold_o = armed;

  // R4
  hold_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_hold_o && ctrl_valid_i && !stop_i && ctrl_byte_i[7:5] == 3'b110 &&
     ctrl_byte_i[2:0] == 3'b111) |=> bus_hold_o);
endmodule

// File: tb/tb_sermod_top.sv
module tb_sermod_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, strobe = 1'b0, stop = 1'b0;
  logic [7:0] cbyte = 8'h00;
  logic mod, hold;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_armed = 0, m_manch = 0, m_mod = 0, m_bit = 0, m_scl = 1;

  always #5 clk = ~clk;

  sermod_top dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .ctrl_valid_i(strobe),
    .ctrl_byte_i(cbyte), .stop_i(stop), .mod_o(mod), .bus_hold_o(hold)
  );

  always @(posedge clk) begin
    bit r, f;
    r = scl && !m_scl;
    f = !scl && m_scl;
    if (rst) begin
      m_armed = 0; m_mod = 0; m_scl = 1;
    end else begin
      if (stop || !m_armed) m_mod = 0;
      else if (r) begin
        m_bit = sda;
        m_mod = m_manch ? sda : !m_mod;
      end else if (f) begin
        if (m_manch) m_mod = !m_bit;
        else if (!m_bit) m_mod = !m_mod;
      end
      if (stop) m_armed = 0;
      else if (!m_armed && strobe && cbyte[7:5] == 3'b110 && cbyte[2:0] == 3'b111) begin
        m_armed = 1; m_manch = cbyte[4];
      end
      m_scl = scl;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (mod !== m_mod || hold !== m_armed) begin
        errors++;
        $display("FAIL %s model: mod=%b hold=%b expected mod=%b hold=%b",
                 cur_req, mod, hold, m_mod, m_armed);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [7:0] b);
    strobe = 1'b1; cbyte = b;
    tick(1);
    strobe = 1'b0;
  endtask

  task automatic send(input logic b, input logic hi, input logic lo, input string req);
    sda = b;
    tick(2);
    scl = 1'b1;
    tick(1);
    chk(mod, hi, req);
    tick(2);
    scl = 1'b0;
    tick(1);
    chk(mod, lo, req);
    tick(1);
  endtask

  task automatic do_stop(input string req);
    stop = 1'b1;
    tick(1);
    stop = 1'b0;
    chk(mod, 1'b0, req);
    chk(hold, 1'b0, req);
    scl = 1'b1;
    tick(2);
  endtask

  task automatic report;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    cur_req = "R1";
    chk(mod, 1'b0, "R1");
    chk(hold, 1'b0, "R1");

    // R3: non-arming control bytes
    cur_req = "R3";
    scl = 1'b0;
    foreach (cbyte_list[i]) begin
      arm(cbyte_list[i]);
      chk(hold, 1'b0, "R3");
      send(1'b1, 1'b0, 1'b0, "R3");
      send(1'b0, 1'b0, 1'b0, "R3");
    end

    // R2/R4/R5: Manchester, bits 1,0,1,1
    cur_req = "R5";
    arm(8'b1101_0111);
    chk(hold, 1'b1, "R4");
    chk(mod, 1'b0, "R7");
    send(1'b1, 1'b1, 1'b0, "R5");
    send(1'b0, 1'b0, 1'b1, "R5");
    send(1'b1, 1'b1, 1'b0, "R5");
    send(1'b1, 1'b1, 1'b0, "R2");

    // R10: SDA moving while SCL low has no effect
    cur_req = "R10";
    for (int k = 0; k < 4; k++) begin
      sda = ~sda;
      tick(1);
      chk(mod, 1'b0, "R10");
    end

    // R9: strobe for Bi-phase while armed is ignored
    cur_req = "R9";
    arm(8'b1100_0111);
    send(1'b1, 1'b1, 1'b0, "R9");

    // R11: long stream with no acknowledge gap
    cur_req = "R11";
    for (int k = 0; k < 20; k++) begin
      logic b;
      b = logic'((k * 7 + 3) % 5 < 2);
      send(b, b, ~b, "R11");
    end
    cur_req = "R8";
    do_stop("R8");

    // R6: Bi-phase (bit 3 set, must not matter), bits 1,0,0,1,1
    cur_req = "R6";
    scl = 1'b0;
    tick(1);
    arm(8'b1100_1111);
    chk(hold, 1'b1, "R2");
    send(1'b1, 1'b1, 1'b1, "R6");
    send(1'b0, 1'b0, 1'b1, "R6");
    send(1'b0, 1'b0, 1'b1, "R6");
    send(1'b1, 1'b0, 1'b0, "R6");
    send(1'b1, 1'b1, 1'b1, "R6");

    // R8: STOP in the same cycle as an SCL rise, mod currently 1
    cur_req = "R8";
    scl = 1'b0;
    tick(2);
    sda = 1'b1;
    scl = 1'b1;
    do_stop("R8");

    // R8: STOP together with an arming strobe
    scl = 1'b0;
    tick(1);
    strobe = 1'b1; cbyte = 8'b1101_0111; stop = 1'b1;
    tick(1);
    strobe = 1'b0; stop = 1'b0;
    chk(hold, 1'b0, "R8");

    // R7: after STOP the block stays low with SCL running
    cur_req = "R7";
    send(1'b1, 1'b0, 1'b0, "R7");

    // R4: hold drops after STOP and rises again on re-arm
    cur_req = "R4";
    arm(8'b1101_1111);
    chk(hold, 1'b1, "R4");
    send(1'b0, 1'b0, 1'b1, "R5");
    do_stop("R4");

    tick(3);
    report();
  end

  logic [7:0] cbyte_list [4] = '{8'b1110_0111, 8'b1100_0110, 8'b1101_0110, 8'b0100_0111};
endmodule